// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block sits on the active-low chip-enable line of a static RAM. A memory controller or address decoder drives its request into the block. An external voltage comparator supplies a digitized power-fail flag. The block drives the chip-enable pin that the RAM actually sees.

While the supply is good, the request reaches the RAM through a single OR gate, with no clocked latency. When the supply fails and the RAM is idle, the RAM is write-protected by holding its enable high. If an access is in flight, that access may complete, but only within a bounded number of cycles. After the supply returns, the RAM stays protected for a long recovery hold-off, so that the processor can settle before it reaches memory again.

The flag passes through a two-stage synchronizer before the sequencer acts on it. A supply-tolerance select input is forwarded unchanged to the comparator, which sets its own threshold from that level. The write-protect timeout and the recovery hold-off are parameters counted in clock cycles.

Top module: `pfce_gate`

## Requirements
- R1: While reset is held, `ce_mem_n` is 1. After reset is released with `pwr_fail_async` low, `ce_mem_n` stays 1 for 2 + REC_CYCLES clock edges. From edge 3 + REC_CYCLES it follows `ce_req_n`.
- R2: In the pass state, `ce_mem_n` equals `ce_req_n` combinationally, in the same cycle, for both levels of the request.
- R3: When `pwr_fail_async` rises while `ce_req_n` is 1, `ce_mem_n` is forced to 1 from the third rising clock edge onward. It stays 1 whatever `ce_req_n` does.
- R4: When `pwr_fail_async` rises while `ce_req_n` is 0, `ce_mem_n` keeps following `ce_req_n` until the request returns to 1. From the next clock edge onward, `ce_mem_n` is held at 1.
- R5: If the in-flight access has not ended WPT_CYCLES edges after the block starts waiting for it, `ce_mem_n` is forced to 1 even while `ce_req_n` stays 0. The block starts waiting on the third edge after the flag rises, and `ce_mem_n` is forced on edge 3 + WPT_CYCLES.
- R6: After `pwr_fail_async` falls, `ce_mem_n` stays 1 for 2 + REC_CYCLES edges, whatever `ce_req_n` does. It follows the request from edge 3 + REC_CYCLES.
- R7: If the flag reasserts during the recovery hold-off, the block returns to protection. The full REC_CYCLES hold-off restarts from zero after the flag falls again.
- R8: `thresh_sel_out` equals `thresh_sel_in` at all times. A 0 selects the 5 % tolerance threshold and a 1 selects the 10 % tolerance threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_req_n | input | 1 | Active-low chip-enable request from the decoder |
| pwr_fail_async | input | 1 | Power-fail flag from the comparator, asynchronous, 1 = supply bad |
| thresh_sel_in | input | 1 | Tolerance select: 0 = 5 %, 1 = 10 % |
| thresh_sel_out | output | 1 | Tolerance select forwarded to the comparator |
| ce_mem_n | output | 1 | Conditioned active-low chip-enable to the RAM |

## Verification
A wrong sequencer state shows at `ce_mem_n` within one cycle. A stray pass state lets the request through while the supply is bad. A stray protect state blocks a valid request. A wrong timer shows as a protection edge or a release edge that lands off the cycle the parameters predict. For this reason the bench samples the cycle before each boundary and the cycle on it. Wrong drain handling shows either as an access cut off before the request rises, or as an enable still low one cycle after the timeout.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROTECT = 2'd2,
        ST_RECOVER = 2'd3
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
        logic        protect;
    } gate_ctl_t;

    localparam gate_ctl_t CTL_RESET = '{state: ST_PROTECT, protect: 1'b1};

    function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

    function automatic logic holds_protect(gate_state_e s);
        return (s == ST_PROTECT) || (s == ST_RECOVER);
    endfunction

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfce_timer.sv
module pfce_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (clr) count <= '0;
        else if (en)  count <= count + 1'b1;
    end
endmodule

// File: rtl/pfce_fsm.sv
module pfce_fsm
    import pfce_pkg::*;
#(
    parameter int unsigned WPT_CYCLES = 4000,
    parameter int unsigned REC_CYCLES = 8000000,
    parameter int unsigned CW         = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fail_s,
    input  logic          ce_req_n,
    input  logic [CW-1:0] count,
    output gate_state_e   state,
    output logic          protect_q,
    output logic          tmr_clr,
    output logic          tmr_en
);
    localparam logic [CW-1:0] WPT_LAST = CW'(WPT_CYCLES - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CYCLES - 1);

    gate_ctl_t   ctl_q;
    gate_ctl_t   ctl_d;
    gate_state_e nxt;

    always_comb begin
        nxt = ctl_q.state;
        unique case (ctl_q.state)
            ST_PASS:    if (fail_s) nxt = ce_req_n ? ST_PROTECT : ST_DRAIN;
            ST_DRAIN:   if (ce_req_n || count == WPT_LAST) nxt = ST_PROTECT;
            ST_PROTECT: if (!fail_s) nxt = ST_RECOVER;
            ST_RECOVER: begin
                if (fail_s)                nxt = ST_PROTECT;
                else if (count == REC_LAST) nxt = ST_PASS;
            end
            default:    nxt = ST_PROTECT;
        endcase
        ctl_d.state   = nxt;
        ctl_d.protect = holds_protect(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_d;
    end

    assign state     = ctl_q.state;
    assign protect_q = ctl_q.protect;
    assign tmr_clr   = (nxt != ctl_q.state);
    assign tmr_en    = (ctl_q.state == ST_DRAIN) || (ctl_q.state == ST_RECOVER);
endmodule

// File: rtl/pfce_gate.sv
module pfce_gate
    import pfce_pkg::*;
#(
    parameter int unsigned WPT_CYCLES  = 4000,
    parameter int unsigned REC_CYCLES  = 8000000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_req_n,
    input  logic pwr_fail_async,
    input  logic thresh_sel_in,
    output logic thresh_sel_out,
    output logic ce_mem_n
);
    localparam int unsigned CW = cnt_width(WPT_CYCLES, REC_CYCLES);

    logic          fail_sync;
    logic [CW-1:0] tmr_count;
    logic          tmr_clr;
    logic          tmr_en;
    logic          protect_q;
    gate_state_e   state;

    pfce_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pwr_fail_async),
        .q   (fail_sync)
    );

    pfce_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .count (tmr_count)
    );

    pfce_fsm #(.WPT_CYCLES(WPT_CYCLES), .REC_CYCLES(REC_CYCLES), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .fail_s    (fail_sync),
        .ce_req_n  (ce_req_n),
        .count     (tmr_count),
        .state     (state),
        .protect_q (protect_q),
        .tmr_clr   (tmr_clr),
        .tmr_en    (tmr_en)
    );

    assign ce_mem_n       = ce_req_n | protect_q;
    assign thresh_sel_out = thresh_sel_in;
endmodule

// File: rtl/pfce_gate_chk.sv
module pfce_gate_chk
    import pfce_pkg::*;
#(
    parameter int unsigned WPT_CYCLES = 4000,
    parameter int unsigned REC_CYCLES = 8000000
) (
    input logic        clk,
    input logic        rst,
    input logic        ce_req_n,
    input logic        ce_mem_n,
    input logic        fail_s,
    input gate_state_e state
);
    logic [31:0] drain_run;
    logic [31:0] rec_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_run <= '0;
            rec_run   <= '0;
        end else begin
            drain_run <= (state == ST_DRAIN)   ? drain_run + 1 : '0;
            rec_run   <= (state == ST_RECOVER) ? rec_run + 1   : '0;
        end
    end

    p_pass_follow_r2: assert property (@(posedge clk) disable iff (rst)
        state == ST_PASS |-> ce_mem_n == ce_req_n);

    p_idle_fail_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS && fail_s && ce_req_n) |=> state == ST_PROTECT);

    p_protect_high_r3: assert property (@(posedge clk) disable iff (rst)
        state == ST_PROTECT |-> ce_mem_n);

    p_drain_end_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && ce_req_n) |=> state == ST_PROTECT);

    p_drain_bound_r5: assert property (@(posedge clk) disable iff (rst)
        state == ST_DRAIN |-> drain_run < WPT_CYCLES);

    p_recover_high_r6: assert property (@(posedge clk) disable iff (rst)
        state == ST_RECOVER |-> ce_mem_n);

    p_recover_min_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && rec_run < REC_CYCLES - 1) |=> state != ST_PASS);

    p_refail_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && fail_s) |=> state == ST_PROTECT);
endmodule

bind pfce_gate pfce_gate_chk #(
    .WPT_CYCLES (WPT_CYCLES),
    .REC_CYCLES (REC_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_req_n (ce_req_n),
    .ce_mem_n (ce_mem_n),
    .fail_s   (fail_sync),
    .state    (state)
);

// File: tb/pfce_gate_tb.sv
`timescale 1ns/1ps
module pfce_gate_tb;
    localparam int unsigned WPT = 20;
    localparam int unsigned REC = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_req_n = 1'b1;
    logic pwr_fail_async = 1'b0;
    logic thresh_sel_in = 1'b0;
    logic thresh_sel_out;
    logic ce_mem_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pfce_gate #(.WPT_CYCLES(WPT), .REC_CYCLES(REC), .SYNC_STAGES(2)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .ce_req_n       (ce_req_n),
        .pwr_fail_async (pwr_fail_async),
        .thresh_sel_in  (thresh_sel_in),
        .thresh_sel_out (thresh_sel_out),
        .ce_mem_n       (ce_mem_n)
    );

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic go_valid();
        pwr_fail_async = 1'b0;
        cyc(3 + REC);
    endtask

    task automatic t_reset();
        ce_req_n = 1'b0;
        cyc(4);
        #1 chk("R1 during reset", ce_mem_n, 1'b1);
        rst = 1'b0;
        cyc(2 + REC);
        #1 chk("R1 last held edge", ce_mem_n, 1'b1);
        cyc(1);
        #1 chk("R1 released", ce_mem_n, 1'b0);
        ce_req_n = 1'b1;
        #1 chk("R1 follow high", ce_mem_n, 1'b1);
    endtask

    task automatic t_pass();
        ce_req_n = 1'b0; #1 chk("R2 low", ce_mem_n, 1'b0);
        ce_req_n = 1'b1; #1 chk("R2 high", ce_mem_n, 1'b1);
        cyc(1);
        ce_req_n = 1'b0; #1 chk("R2 low again", ce_mem_n, 1'b0);
        ce_req_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_idle_fail();
        ce_req_n = 1'b1;
        pwr_fail_async = 1'b1;
        cyc(2);
        ce_req_n = 1'b0;
        #1 chk("R3 before third edge", ce_mem_n, 1'b0);
        ce_req_n = 1'b1;
        cyc(1);
        ce_req_n = 1'b0;
        #1 chk("R3 forced", ce_mem_n, 1'b1);
        cyc(10);
        #1 chk("R3 still forced", ce_mem_n, 1'b1);
        ce_req_n = 1'b1;
    endtask

    task automatic t_recover();
        pwr_fail_async = 1'b0;
        ce_req_n = 1'b0;
        cyc(10);
        #1 chk("R6 mid hold", ce_mem_n, 1'b1);
        cyc(REC - 8);
        #1 chk("R6 last held edge", ce_mem_n, 1'b1);
        cyc(1);
        #1 chk("R6 released", ce_mem_n, 1'b0);
        ce_req_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_drain_end();
        ce_req_n = 1'b0;
        pwr_fail_async = 1'b1;
        cyc(3);
        #1 chk("R4 access continues", ce_mem_n, 1'b0);
        cyc(5);
        #1 chk("R4 access still on", ce_mem_n, 1'b0);
        ce_req_n = 1'b1;
        #1 chk("R4 request ends", ce_mem_n, 1'b1);
        cyc(1);
        ce_req_n = 1'b0;
        #1 chk("R4 protected after end", ce_mem_n, 1'b1);
        ce_req_n = 1'b1;
        go_valid();
    endtask

    task automatic t_timeout();
        ce_req_n = 1'b0;
        pwr_fail_async = 1'b1;
        cyc(2 + WPT);
        #1 chk("R5 before timeout", ce_mem_n, 1'b0);
        cyc(1);
        #1 chk("R5 timeout forces", ce_mem_n, 1'b1);
        ce_req_n = 1'b1;
        go_valid();
    endtask

    task automatic t_refail();
        pwr_fail_async = 1'b1;
        cyc(4);
        pwr_fail_async = 1'b0;
        cyc(3 + 30);
        pwr_fail_async = 1'b1;
        cyc(5);
        ce_req_n = 1'b0;
        #1 chk("R7 protected again", ce_mem_n, 1'b1);
        pwr_fail_async = 1'b0;
        cyc(2 + REC);
        #1 chk("R7 full hold restarted", ce_mem_n, 1'b1);
        cyc(1);
        #1 chk("R7 released", ce_mem_n, 1'b0);
        ce_req_n = 1'b1;
    endtask

    task automatic t_thresh();
        thresh_sel_in = 1'b1; #1 chk("R8 select 10%", thresh_sel_out, 1'b1);
        thresh_sel_in = 1'b0; #1 chk("R8 select 5%", thresh_sel_out, 1'b0);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_pass();
        t_thresh();
        t_idle_fail();
        t_recover();
        t_drain_end();
        t_timeout();
        t_refail();
        t_pass();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule